// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Edge Detection

The controller manages 64 general-purpose pins from a simple 32-bit register bus. Each pin has an input, an output value and an output-enable. Software chooses the direction of each pin. It changes output values only through two strobe registers: one forces the addressed latch bits high and the other forces them low. Because of this, no read-modify-write of the output latch is ever needed.

Every pin input passes through a two-flop synchroniser. The synchronised value can be read back, and it also feeds an edge detector. Each pin has its own rising-edge and falling-edge enable. When an enabled edge is seen, a sticky status bit is set. Software clears a status bit by writing 1 to it. The single interrupt line is high while any status bit is set.

The bus uses word addresses. Address bits [3:1] select the register kind and bit 0 selects the word: 0 for pins 0-31, 1 for pins 32-63. The decoder sorts each access into one of eight register kinds:
- level
- direction
- set strobe
- clear strobe
- rising enable
- falling enable
- status
- unmapped

The write path and the read mux each take a single unique case over these kinds. There is no sequencing between accesses. Every access completes in the cycle it is presented.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Pin n lives in word n/32, bit n%32. The word address selects the register as follows: 0-1 level, 2-3 direction, 4-5 set strobe, 6-7 clear strobe, 8-9 rising enable, 10-11 falling enable, 12-13 status. Even addresses hold pins 0-31 and odd addresses hold pins 32-63.
- R2: A level read returns pin_in after two-flop synchronisation. A pin_in change made before a clock edge is not yet visible after that edge. It is visible after the second edge.
- R3: The direction register can be read and written. pin_oe equals its bits, and 1 means output.
- R4: A write to the set strobe drives to 1 every output latch bit whose written bit is 1. Bits written as 0 are left unchanged. The set strobe reads as zero. pin_out shows the latch.
- R5: A write to the clear strobe drives to 0 every output latch bit whose written bit is 1. Bits written as 0 are left unchanged. The clear strobe reads as zero.
- R6: The rising and falling enables can be read and written, and each pin's two enables act independently. A status bit is set only by an edge whose enable is set. If both enables are set, both edge directions are captured. The status bit becomes visible after the third clock edge following the pin_in change.
- R7: Status bits are sticky. Writing 1 clears a status bit, and writing 0 has no effect. If a new enabled edge arrives in the same cycle as a clear of that bit, the bit stays set.
- R8: irq is high exactly when at least one status bit is set.
- R9: After reset, the following are all zero: output latch, direction, both enables, status, pin_out, pin_oe and irq.
- R10: Writes to the level words and to unmapped addresses 14-15 change nothing. Reads of addresses 14-15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current register state |
| pin_in | input | 64 | Pin inputs (asynchronous) |
| pin_out | output | 64 | Output latch |
| pin_oe | output | 64 | Output enable (direction) |
| irq | output | 1 | Combined edge interrupt |

## Verification
Register writes take effect at the clock edge that samples them. The bench therefore reads back at the falling edge after that edge. Reads are combinational, so a read is sampled a moment after its address is driven.

A pin_in change is driven at a falling edge, and the bench counts rising edges from that point:
- After one rising edge, the level read is checked to still show the old value.
- After two rising edges, the level read is checked to show the new value.
- After three rising edges, the status bits and irq are checked.

For the collision case, the clear write is placed so that the clock edge which samples it is that same third edge.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    // Register kind, taken from word address bits [3:1]; the order is the bus map.
    typedef enum logic [2:0] {
        RK_LEVEL = 3'd0,
        RK_DIR   = 3'd1,
        RK_SET   = 3'd2,
        RK_CLR   = 3'd3,
        RK_RISE  = 3'd4,
        RK_FALL  = 3'd5,
        RK_STAT  = 3'd6,
        RK_NONE  = 3'd7
    } reg_kind_e;

    localparam int KIND_W = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_edge_pkg::*;
#(
    parameter int IDX_W = 1
) (
    input  logic [KIND_W+IDX_W-1:0] waddr,
    output reg_kind_e               kind,
    output logic [IDX_W-1:0]        word_idx
);
    logic [KIND_W-1:0] kind_raw;

    assign kind_raw = waddr[KIND_W+IDX_W-1:IDX_W];
    assign word_idx = waddr[IDX_W-1:0];

    always_comb begin
        unique case (kind_raw)
            3'd0:    kind = RK_LEVEL;
            3'd1:    kind = RK_DIR;
            3'd2:    kind = RK_SET;
            3'd3:    kind = RK_CLR;
            3'd4:    kind = RK_RISE;
            3'd5:    kind = RK_FALL;
            3'd6:    kind = RK_STAT;
            default: kind = RK_NONE;
        endcase
    end
endmodule

// File: rtl/gpio_edge_word.sv
module gpio_edge_word #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    logic [W-1:0] prev_q;
    logic [W-1:0] status_q;
    logic [W-1:0] hit;

    assign hit = (level & ~prev_q & rise_en) | (~level & prev_q & fall_en);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            status_q <= '0;
        end else begin
            prev_q   <= level;
            // a fresh edge wins over a clear aimed at the same bit
            status_q <= (status_q & ~clr_mask) | hit;
        end
    end

    assign status = status_q;

    // R7: a set bit not targeted by a clear stays set
    assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status & $past(status & ~clr_mask)) == $past(status & ~clr_mask)));

    // R6: a newly set bit always had at least one enable in the cycle before
    assert_new_status_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status & ~$past(status) & ~$past(rise_en | fall_en)) == '0));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int WORD_W   = 32,
    parameter int NWORDS   = NUM_PINS / WORD_W,
    parameter int IDX_W    = $clog2(NWORDS),
    parameter int WADDR_W  = KIND_W + IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [WADDR_W-1:0]  bus_waddr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    reg_kind_e        kind;
    logic [IDX_W-1:0] word_idx;
    logic             wr_fire;

    logic [NWORDS-1:0][WORD_W-1:0] dir_q;
    logic [NWORDS-1:0][WORD_W-1:0] out_q;
    logic [NWORDS-1:0][WORD_W-1:0] rise_q;
    logic [NWORDS-1:0][WORD_W-1:0] fall_q;
    logic [NWORDS-1:0][WORD_W-1:0] lvl_w;
    logic [NWORDS-1:0][WORD_W-1:0] stat_w;
    logic [NUM_PINS-1:0]           lvl;

    gpio_bus_decode #(.IDX_W(IDX_W)) u_decode (
        .waddr    (bus_waddr),
        .kind     (kind),
        .word_idx (word_idx)
    );

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (lvl)
    );

    assign lvl_w   = lvl;
    assign wr_fire = bus_sel && bus_wr;

    genvar w;
    generate
        for (w = 0; w < NWORDS; w++) begin : g_word
            logic [WORD_W-1:0] clr_mask;
            assign clr_mask = (wr_fire && kind == RK_STAT && word_idx == IDX_W'(w))
                              ? bus_wdata : '0;
            gpio_edge_word #(.W(WORD_W)) u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .level    (lvl_w[w]),
                .rise_en  (rise_q[w]),
                .fall_en  (fall_q[w]),
                .clr_mask (clr_mask),
                .status   (stat_w[w])
            );
        end
    endgenerate

    // register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (wr_fire) begin
            unique case (kind)
                RK_DIR:  dir_q[word_idx]  <= bus_wdata;
                RK_SET:  out_q[word_idx]  <= out_q[word_idx] | bus_wdata;
                RK_CLR:  out_q[word_idx]  <= out_q[word_idx] & ~bus_wdata;
                RK_RISE: rise_q[word_idx] <= bus_wdata;
                RK_FALL: fall_q[word_idx] <= bus_wdata;
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (kind)
                RK_LEVEL: bus_rdata = lvl_w[word_idx];
                RK_DIR:   bus_rdata = dir_q[word_idx];
                RK_RISE:  bus_rdata = rise_q[word_idx];
                RK_FALL:  bus_rdata = fall_q[word_idx];
                RK_STAT:  bus_rdata = stat_w[word_idx];
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |stat_w;

    // write data placed at its word position across the pin vector
    logic [NUM_PINS-1:0] wr_mask;
    assign wr_mask = {{(NUM_PINS-WORD_W){1'b0}}, bus_wdata} << (word_idx * WORD_W);

    assert_set_drives_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && kind == RK_SET) |=> ((pin_out & $past(wr_mask)) == $past(wr_mask)));

    assert_clr_drives_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && kind == RK_CLR) |=> ((pin_out & $past(wr_mask)) == '0));

    assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_fire && (kind == RK_SET || kind == RK_CLR)) |=> $stable(pin_out));

    assert_oe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_fire && kind == RK_DIR) |=> $stable(pin_oe));
endmodule

// File: tb/gpio_edge_ctrl_bench.sv
module gpio_edge_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] pin_in = '0;
    logic [63:0] pin_out;
    logic [63:0] pin_oe;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    gpio_edge_ctrl u_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    localparam int K_LVL = 0, K_DIR = 1, K_SET = 2, K_CLR = 3, K_RISE = 4, K_FALL = 5, K_STAT = 6;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = 4'(a);
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wr64(input int k, input logic [63:0] d);
        wr(k*2, d[31:0]);
        wr(k*2+1, d[63:32]);
    endtask

    task automatic rd64(input int k, output logic [63:0] d);
        logic [31:0] lo, hi;
        rd(k*2, lo);
        rd(k*2+1, hi);
        d = {hi, lo};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v, exp_out, exp_dir, exp_st;
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9 reset state
        for (int k = 0; k < 7; k++) begin
            rd64(k, v);
            chk("R9 reset reg", v, 64'h0);
        end
        chk("R9 pin_out", pin_out, 64'h0);
        chk("R9 pin_oe", pin_oe, 64'h0);
        chk("R9 irq", {63'h0, irq}, 64'h0);

        // R3 direction patterns
        foreach (v[i]) ;
        begin
            logic [63:0] pats [4];
            pats[0] = 64'hFFFF_FFFF_0000_0000; pats[1] = 64'h0000_0000_FFFF_FFFF;
            pats[2] = 64'hA5A5_3C3C_0F0F_8001; pats[3] = 64'h0;
            for (int p = 0; p < 4; p++) begin
                wr64(K_DIR, pats[p]);
                rd64(K_DIR, v);
                chk("R3 dir readback", v, pats[p]);
                chk("R3 pin_oe", pin_oe, pats[p]);
            end
        end
        exp_dir = 64'h0;

        // R1 R4 set sweep, one pin at a time
        exp_out = 64'h0;
        for (int n = 0; n < 64; n++) begin
            wr((K_SET*2) + n/32, 32'h1 << (n%32));
            exp_out[n] = 1'b1;
            chk("R1 R4 set pin", pin_out, exp_out);
        end
        rd(K_SET*2, r);   chk("R4 set reads zero", {32'h0, r}, 64'h0);
        rd(K_SET*2+1, r); chk("R4 set reads zero", {32'h0, r}, 64'h0);
        // R5 clear sweep
        for (int n = 0; n < 64; n += 1) begin
            wr((K_CLR*2) + n/32, 32'h1 << (n%32));
            exp_out[n] = 1'b0;
            chk("R1 R5 clear pin", pin_out, exp_out);
        end
        rd(K_CLR*2, r);   chk("R5 clear reads zero", {32'h0, r}, 64'h0);
        // zero bits have no effect
        wr64(K_SET, 64'hA5A5_0F0F_5A5A_F0F0);
        exp_out = 64'hA5A5_0F0F_5A5A_F0F0;
        wr64(K_SET, 64'h0);
        chk("R4 zero set no effect", pin_out, exp_out);
        wr64(K_CLR, 64'h0);
        chk("R5 zero clear no effect", pin_out, exp_out);
        wr64(K_CLR, 64'h0000_FFFF_0000_00F0);
        exp_out = exp_out & ~64'h0000_FFFF_0000_00F0;
        chk("R5 partial clear", pin_out, exp_out);

        // R2 level timing, walking one
        for (int n = 0; n < 64; n += 7) begin
            @(negedge clk) pin_in = 64'h1 << n;
            @(posedge clk);
            rd(K_LVL*2 + n/32, r);
            chk("R2 level after one edge", {32'h0, r}, 64'h0);
            rd(K_LVL*2 + n/32, r);
            chk("R2 level after two edges", {32'h0, r}, {32'h0, 32'h1 << (n%32)});
            @(negedge clk) pin_in = 64'h0;
            repeat (4) @(posedge clk);
        end

        // R6 R8 edge sweep over enable modes and every pin
        for (int m = 0; m < 4; m++) begin
            wr64(K_RISE, m[0] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0);
            wr64(K_FALL, m[1] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0);
            rd64(K_RISE, v); chk("R6 rise enable readback", v, m[0] ? '1 : 64'h0);
            wr64(K_STAT, '1);
            for (int n = 0; n < 64; n++) begin
                @(negedge clk) pin_in[n] = 1'b1;
                repeat (3) @(posedge clk);
                rd64(K_STAT, v);
                exp_st = m[0] ? (64'h1 << n) : 64'h0;
                chk("R6 rising capture", v, exp_st);
                chk("R8 irq on rise", {63'h0, irq}, {63'h0, exp_st != 0});
                wr64(K_STAT, '1);
                @(negedge clk) pin_in[n] = 1'b0;
                repeat (3) @(posedge clk);
                rd64(K_STAT, v);
                exp_st = m[1] ? (64'h1 << n) : 64'h0;
                chk("R6 falling capture", v, exp_st);
                chk("R8 irq on fall", {63'h0, irq}, {63'h0, exp_st != 0});
                wr64(K_STAT, '1);
                chk("R7 w1c clears all", {63'h0, irq}, 64'h0);
            end
        end

        // R6 per-pin independence
        wr64(K_RISE, 64'h5555_5555_5555_5555);
        wr64(K_FALL, 64'h0);
        @(negedge clk) pin_in = '1;
        repeat (3) @(posedge clk);
        rd64(K_STAT, v);
        chk("R6 per-pin rise mask", v, 64'h5555_5555_5555_5555);

        // R7 sticky, zero write, partial clear
        repeat (10) @(posedge clk);
        rd64(K_STAT, v);  chk("R7 sticky", v, 64'h5555_5555_5555_5555);
        wr64(K_STAT, 64'h0);
        rd64(K_STAT, v);  chk("R7 zero write no effect", v, 64'h5555_5555_5555_5555);
        wr64(K_STAT, 64'h0000_0001_0000_0004);
        rd64(K_STAT, v);  chk("R7 partial clear", v, 64'h5555_5554_5555_5551);
        wr64(K_STAT, '1);
        chk("R8 irq low when clear", {63'h0, irq}, 64'h0);

        // R7 collision: new falling edge on pin 2 in the clear cycle
        wr64(K_FALL, 64'h4);
        @(negedge clk) pin_in[2] = 1'b0;
        repeat (3) @(posedge clk);
        rd64(K_STAT, v);  chk("R7 pre-set bit", v, 64'h4);
        @(negedge clk) pin_in[2] = 1'b1;
        @(negedge clk) pin_in[2] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        wr(K_STAT*2, 32'h4);
        rd64(K_STAT, v);  chk("R7 edge beats clear", v, 64'h4);
        wr(K_STAT*2, 32'h4);
        rd64(K_STAT, v);  chk("R7 plain clear", v, 64'h0);

        // R10 level writes and unmapped addresses
        wr64(K_RISE, 64'h0);
        wr64(K_FALL, 64'h0);
        wr64(K_DIR, 64'h0F0F);
        exp_dir = 64'h0F0F;
        @(negedge clk) pin_in = 64'h0000_0000_1234_5678;
        repeat (3) @(posedge clk);
        wr(0, 32'hFFFF_FFFF);
        wr(1, 32'hFFFF_FFFF);
        wr(14, 32'hFFFF_FFFF);
        wr(15, 32'hFFFF_FFFF);
        rd64(K_LVL, v);  chk("R10 level write ignored", v, 64'h0000_0000_1234_5678);
        rd(14, r);       chk("R10 unmapped reads zero", {32'h0, r}, 64'h0);
        rd(15, r);       chk("R10 unmapped reads zero", {32'h0, r}, 64'h0);
        chk("R10 pin_out unchanged", pin_out, exp_out);
        chk("R10 pin_oe unchanged", pin_oe, exp_dir);
        rd64(K_STAT, v); chk("R10 status unchanged", v, 64'h0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule